// File: doc/BRIEF.md
# DAC Power Sequencing Controller

This controller steps a stereo audio converter from its low-power reset condition up to normal analog output, and back down again when clocks disappear or the external reset is pulled low. Its inputs are an asynchronous active-low reset, qualifier flags that say the master, frame and bit clocks are present, a ratio detector's "ratio valid" and "ratio changed" flags, and a completion strobe from the charge-pump bring-up logic. It drives six enables: charge pump, output pull-downs, filters and modulators, voltage reference, output amplifiers, and mute.

The sequence runs from reset, through power-down (waiting for the master clock) and charge-pump initialization, then ratio detection and a timed power-up phase, to normal operation. A change of clock ratio during normal operation sends the block to a muted state, and it returns to normal once a valid ratio is seen again. If the master clock is lost anywhere past power-down, the block falls back to power-down. A startup watchdog raises a sticky flag if normal operation is not reached within a programmable number of cycles after reset release. That limit stands for the startup-latency budget of under 50 ms.

The state is exposed one-hot so that a neighbour can decode it directly. All enables come from registers.

Top module: `dac_pwr_seq`

## Requirements
- R1: `state_oh` is always one-hot. The bit map is: bit 0 reset, bit 1 power-down, bit 2 init, bit 3 ratio-detect, bit 4 power-up, bit 5 normal, bit 6 mute.
- R2: While `arst_n` is low, the block is in reset at once, without waiting for a clock edge. In reset, `pulldn_en`=1 and `mute`=1, and every other enable is 0. After `arst_n` rises, the block enters power-down on the third rising clock edge (two synchronizer stages, then the state register).
- R3: In power-down, the block stays put while `mclk_ok`=0. It moves to init on the edge where `mclk_ok`=1 is sampled.
- R4: In init, `cp_en`=1. The block moves to ratio-detect only when `cp_done`, `lrck_ok` and `sclk_ok` are all 1.
- R5: In ratio-detect, the block returns to init if `lrck_ok` or `sclk_ok` is 0. Otherwise it moves to power-up when `ratio_ok`=1, and it waits while `ratio_ok`=0.
- R6: In power-up, `filt_en`, `vref_en` and `amp_en` are 1, and `pulldn_en` stays 1. Power-up lasts exactly PUP_CYCLES cycles (4 by default) before the block enters normal.
- R7: In normal, `pulldn_en`=0 and `mute`=0. `pulldn_en` only falls in a cycle where `amp_en` was already 1 in the previous cycle.
- R8: In normal, `ratio_chg`=1 moves the block to mute, where `mute`=1 and the amplifiers stay on. In mute, `ratio_ok`=1 with `ratio_chg`=0 returns the block to normal.
- R9: In any of init, ratio-detect, power-up, normal or mute, `mclk_ok`=0 moves the block to power-down on the next edge.
- R10: Enables change on the same clock edge as the state that selects them. If every input is already valid when reset is released, normal is reached PUP_CYCLES+6 edges after the release (10 edges by default).
- R11: `startup_timeout` rises if normal is not reached within STARTUP_LIMIT cycles after the synchronized release. Once set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| arst_n | input | 1 | External reset, active low, asynchronous |
| mclk_ok | input | 1 | Master clock present |
| lrck_ok | input | 1 | Frame clock present |
| sclk_ok | input | 1 | Bit clock present |
| ratio_ok | input | 1 | Ratio detector reports a valid master/frame ratio |
| ratio_chg | input | 1 | Ratio detector reports a ratio change |
| cp_done | input | 1 | Charge-pump rails charged |
| cp_en | output | 1 | Charge-pump enable |
| pulldn_en | output | 1 | Output pull-down enable |
| filt_en | output | 1 | Filter and modulator enable |
| vref_en | output | 1 | Reference normal-operation enable |
| amp_en | output | 1 | Output amplifier power |
| mute | output | 1 | Output mute |
| state_oh | output | 7 | One-hot state |
| startup_timeout | output | 1 | Sticky startup-latency violation |

## Verification
A wrong internal state appears on `state_oh` and the six enables on the very edge that selects it. Outputs are decoded from the next state and then registered, so a bad transition is visible one cycle after the inputs that caused it. An ordering fault in the pull-down release shows up as `pulldn_en` falling without `amp_en` having been high the cycle before. A stalled sequence shows up as a missing arrival in normal, and after STARTUP_LIMIT cycles as a raised `startup_timeout`.

// File: rtl/dps_pkg.sv
package dps_pkg;
  localparam int NST      = 7;
  localparam int IDX_RST  = 0;
  localparam int IDX_PDN  = 1;
  localparam int IDX_INIT = 2;
  localparam int IDX_RDET = 3;
  localparam int IDX_PUP  = 4;
  localparam int IDX_NORM = 5;
  localparam int IDX_MUTE = 6;

  typedef logic [NST-1:0] st_oh_t;

  localparam st_oh_t ST_RST_OH = st_oh_t'(1) << IDX_RST;

  typedef struct packed {
    logic cp_en;
    logic pulldn_en;
    logic filt_en;
    logic vref_en;
    logic amp_en;
    logic mute;
  } enables_t;

  localparam enables_t EN_RESET = '{cp_en: 1'b0, pulldn_en: 1'b1, filt_en: 1'b0,
                                    vref_en: 1'b0, amp_en: 1'b0, mute: 1'b1};
endpackage

// File: rtl/dps_rst_sync.sv
module dps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rs_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rs_n = chain_q[STAGES-1];
endmodule

// File: rtl/dps_fsm.sv
module dps_fsm
  import dps_pkg::*;
#(
  parameter int PUP_CYCLES = 4
) (
  input  logic   clk,
  input  logic   rs_n,
  input  logic   mclk_ok,
  input  logic   lrck_ok,
  input  logic   sclk_ok,
  input  logic   ratio_ok,
  input  logic   ratio_chg,
  input  logic   cp_done,
  output st_oh_t st_q,
  output st_oh_t st_nxt
);
  localparam int PCW = $clog2(PUP_CYCLES + 1);
  localparam logic [PCW-1:0] PUP_LAST = PCW'(PUP_CYCLES - 1);

  logic [PCW-1:0] pup_cnt_q;
  logic [PCW-1:0] pup_cnt_d;
  logic           pup_cnt_en;
  logic           pup_done;
  logic           frame_clks_ok;

  assign frame_clks_ok = lrck_ok & sclk_ok;
  assign pup_cnt_en    = st_q[IDX_PUP];
  assign pup_done      = pup_cnt_en && (pup_cnt_q == PUP_LAST);

  // power-up dwell counter: clears outside power-up
  always_comb begin
    if (!pup_cnt_en) begin
      pup_cnt_d = '0;
    end else begin
      pup_cnt_d = pup_cnt_q + PCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      pup_cnt_q <= '0;
    end else begin
      pup_cnt_q <= pup_cnt_d;
    end
  end

  // next-state decode, master clock loss has priority past power-down
  always_comb begin
    st_nxt = '0;
    if (st_q[IDX_RST]) begin
      st_nxt[IDX_PDN] = 1'b1;
    end else if (st_q[IDX_PDN]) begin
      st_nxt[mclk_ok ? IDX_INIT : IDX_PDN] = 1'b1;
    end else if (!mclk_ok && (|st_q)) begin
      st_nxt[IDX_PDN] = 1'b1;
    end else if (st_q[IDX_INIT]) begin
      st_nxt[(cp_done && frame_clks_ok) ? IDX_RDET : IDX_INIT] = 1'b1;
    end else if (st_q[IDX_RDET]) begin
      if (!frame_clks_ok) begin
        st_nxt[IDX_INIT] = 1'b1;
      end else begin
        st_nxt[ratio_ok ? IDX_PUP : IDX_RDET] = 1'b1;
      end
    end else if (st_q[IDX_PUP]) begin
      st_nxt[pup_done ? IDX_NORM : IDX_PUP] = 1'b1;
    end else if (st_q[IDX_NORM]) begin
      st_nxt[ratio_chg ? IDX_MUTE : IDX_NORM] = 1'b1;
    end else if (st_q[IDX_MUTE]) begin
      st_nxt[(ratio_ok && !ratio_chg) ? IDX_NORM : IDX_MUTE] = 1'b1;
    end else begin
      st_nxt[IDX_RST] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      st_q <= ST_RST_OH;
    end else begin
      st_q <= st_nxt;
    end
  end
endmodule

// File: rtl/dps_outreg.sv
module dps_outreg
  import dps_pkg::*;
(
  input  logic     clk,
  input  logic     rs_n,
  input  st_oh_t   st_nxt,
  output enables_t en_q
);
  enables_t en_d;
  logic     analog_up;

  assign analog_up = st_nxt[IDX_PUP] | st_nxt[IDX_NORM] | st_nxt[IDX_MUTE];

  always_comb begin
    en_d.cp_en     = st_nxt[IDX_INIT] | st_nxt[IDX_RDET] | analog_up;
    en_d.filt_en   = analog_up;
    en_d.vref_en   = analog_up;
    en_d.amp_en    = analog_up;
    en_d.pulldn_en = ~(st_nxt[IDX_NORM] | st_nxt[IDX_MUTE]);
    en_d.mute      = ~st_nxt[IDX_NORM];
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      en_q <= EN_RESET;
    end else begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/dps_startup_mon.sv
module dps_startup_mon #(
  parameter int STARTUP_LIMIT = 600
) (
  input  logic clk,
  input  logic rs_n,
  input  logic in_norm,
  output logic timeout
);
  localparam int CW = $clog2(STARTUP_LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_LIMIT - 1);

  logic          armed_q, armed_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;
  logic          cnt_en;
  logic          hit;

  assign cnt_en = armed_q & ~in_norm;
  assign hit    = cnt_en && (cnt_q == LAST);

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    flag_d  = flag_q;
    if (armed_q && in_norm) begin
      armed_d = 1'b0;
    end
    if (cnt_en) begin
      cnt_d = cnt_q + CW'(1);
    end
    if (hit) begin
      flag_d  = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
      flag_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      flag_q  <= flag_d;
    end
  end

  assign timeout = flag_q;
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dps_pkg::*;
#(
  parameter int PUP_CYCLES    = 4,
  parameter int STARTUP_LIMIT = 600,
  parameter int SYNC_STAGES   = 2
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           mclk_ok,
  input  logic           lrck_ok,
  input  logic           sclk_ok,
  input  logic           ratio_ok,
  input  logic           ratio_chg,
  input  logic           cp_done,
  output logic           cp_en,
  output logic           pulldn_en,
  output logic           filt_en,
  output logic           vref_en,
  output logic           amp_en,
  output logic           mute,
  output logic [NST-1:0] state_oh,
  output logic           startup_timeout
);
  logic     rs_n;
  st_oh_t   st_q;
  st_oh_t   st_nxt;
  enables_t en_q;

  dps_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .rs_n   (rs_n)
  );

  dps_fsm #(.PUP_CYCLES(PUP_CYCLES)) u_fsm (
    .clk       (clk),
    .rs_n      (rs_n),
    .mclk_ok   (mclk_ok),
    .lrck_ok   (lrck_ok),
    .sclk_ok   (sclk_ok),
    .ratio_ok  (ratio_ok),
    .ratio_chg (ratio_chg),
    .cp_done   (cp_done),
    .st_q      (st_q),
    .st_nxt    (st_nxt)
  );

  dps_outreg u_out (
    .clk    (clk),
    .rs_n   (rs_n),
    .st_nxt (st_nxt),
    .en_q   (en_q)
  );

  dps_startup_mon #(.STARTUP_LIMIT(STARTUP_LIMIT)) u_mon (
    .clk     (clk),
    .rs_n    (rs_n),
    .in_norm (st_q[IDX_NORM]),
    .timeout (startup_timeout)
  );

  assign cp_en     = en_q.cp_en;
  assign pulldn_en = en_q.pulldn_en;
  assign filt_en   = en_q.filt_en;
  assign vref_en   = en_q.vref_en;
  assign amp_en    = en_q.amp_en;
  assign mute      = en_q.mute;
  assign state_oh  = st_q;
endmodule

// File: rtl/dps_chk.sv
module dps_chk
  import dps_pkg::*;
(
  input logic           clk,
  input logic           rs_n,
  input logic           mclk_ok,
  input logic           lrck_ok,
  input logic           sclk_ok,
  input logic           ratio_chg,
  input logic [NST-1:0] st,
  input logic           cp_en,
  input logic           pulldn_en,
  input logic           amp_en,
  input logic           mute,
  input logic           startup_timeout
);
  logic past_pdn;
  assign past_pdn = st[IDX_INIT] | st[IDX_RDET] | st[IDX_PUP] | st[IDX_NORM] | st[IDX_MUTE];

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rs_n)
    $countones(st) == 1); // R1
  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rs_n)
    st[IDX_RST] |=> st[IDX_PDN]); // R2
  AST_PDN_WAIT: assert property (@(posedge clk) disable iff (!rs_n)
    (st[IDX_PDN] && !mclk_ok) |=> st[IDX_PDN]); // R3
  AST_INIT_PUMP_ON: assert property (@(posedge clk) disable iff (!rs_n)
    st[IDX_INIT] |-> cp_en); // R4
  AST_RDET_CLK_LOSS: assert property (@(posedge clk) disable iff (!rs_n)
    (st[IDX_RDET] && mclk_ok && !(lrck_ok && sclk_ok)) |=> st[IDX_INIT]); // R5
  AST_PUP_ENABLES: assert property (@(posedge clk) disable iff (!rs_n)
    st[IDX_PUP] |-> (amp_en && pulldn_en)); // R6
  AST_PULLDN_ORDER: assert property (@(posedge clk) disable iff (!rs_n)
    $fell(pulldn_en) |-> $past(amp_en)); // R7
  AST_NORM_UNMUTED: assert property (@(posedge clk) disable iff (!rs_n)
    st[IDX_NORM] |-> (!mute && !pulldn_en)); // R7
  AST_RATIO_MUTE: assert property (@(posedge clk) disable iff (!rs_n)
    (st[IDX_NORM] && mclk_ok && ratio_chg) |=> st[IDX_MUTE]); // R8
  AST_MCLK_LOSS: assert property (@(posedge clk) disable iff (!rs_n)
    (past_pdn && !mclk_ok) |=> st[IDX_PDN]); // R9
  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rs_n)
    startup_timeout |=> startup_timeout); // R11
endmodule

bind dac_pwr_seq dps_chk u_chk (
  .clk             (clk),
  .rs_n            (rs_n),
  .mclk_ok         (mclk_ok),
  .lrck_ok         (lrck_ok),
  .sclk_ok         (sclk_ok),
  .ratio_chg       (ratio_chg),
  .st              (state_oh),
  .cp_en           (cp_en),
  .pulldn_en       (pulldn_en),
  .amp_en          (amp_en),
  .mute            (mute),
  .startup_timeout (startup_timeout)
);

// File: tb/dac_pwr_seq_test.sv
module dac_pwr_seq_test;
  localparam int LIM = 600;
  localparam int PUPC = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic arst_n, mclk_ok, lrck_ok, sclk_ok, ratio_ok, ratio_chg, cp_done;
  logic cp_en, pulldn_en, filt_en, vref_en, amp_en, mute, startup_timeout;
  logic [6:0] state_oh;

  dac_pwr_seq #(.PUP_CYCLES(PUPC), .STARTUP_LIMIT(LIM)) uut (
    .clk(clk), .arst_n(arst_n), .mclk_ok(mclk_ok), .lrck_ok(lrck_ok),
    .sclk_ok(sclk_ok), .ratio_ok(ratio_ok), .ratio_chg(ratio_chg), .cp_done(cp_done),
    .cp_en(cp_en), .pulldn_en(pulldn_en), .filt_en(filt_en), .vref_en(vref_en),
    .amp_en(amp_en), .mute(mute), .state_oh(state_oh), .startup_timeout(startup_timeout)
  );

  typedef struct {
    logic [6:0] st;
    logic [5:0] en;
    logic       tmo;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  event chk_ev;
  int n_chk = 0;
  int n_fail = 0;

  // enables {cp, pulldown, filt, vref, amp, mute} per state, from the requirements
  function automatic logic [5:0] exp_en(logic [6:0] st);
    logic up;
    up = st[4] | st[5] | st[6];
    return {(st[2] | st[3] | up), ~(st[5] | st[6]), up, up, up, ~st[5]};
  endfunction

  task automatic expect_now(int idx, logic tmo, string tag);
    exp_t e;
    e.st  = 7'(1) << idx;
    e.en  = exp_en(e.st);
    e.tmo = tmo;
    e.tag = tag;
    sbq.push_back(e);
    ->chk_ev;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected items and compares against the ports
  initial begin
    exp_t e;
    logic [5:0] act;
    forever begin
      @(chk_ev);
      while (sbq.size() > 0) begin
        e = sbq.pop_front();
        act = {cp_en, pulldn_en, filt_en, vref_en, amp_en, mute};
        n_chk++;
        if (state_oh !== e.st || act !== e.en || startup_timeout !== e.tmo) begin
          n_fail++;
          $display("FAIL %s: state=%b en=%b tmo=%b expected state=%b en=%b tmo=%b",
                   e.tag, state_oh, act, startup_timeout, e.st, e.en, e.tmo);
        end
      end
    end
  end

  // R7 ordering watch: pull-down may only fall after amp was high
  logic prev_pd = 1'b1, prev_amp = 1'b0;
  always @(negedge clk) begin
    if (prev_pd === 1'b1 && pulldn_en === 1'b0) begin
      n_chk++;
      if (prev_amp !== 1'b1) begin
        n_fail++;
        $display("FAIL R7: pull-down fell with prior amp=%b expected 1", prev_amp);
      end
    end
    prev_pd  = pulldn_en;
    prev_amp = amp_en;
  end

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    arst_n = 0; mclk_ok = 0; lrck_ok = 0; sclk_ok = 0;
    ratio_ok = 0; ratio_chg = 0; cp_done = 0;
    cyc(4);
    expect_now(0, 0, "R2 reset state");
    arst_n = 1;
    cyc(2);
    expect_now(0, 0, "R2 still reset during sync");
    cyc(1);
    expect_now(1, 0, "R2 power-down on third edge");
    cyc(5);
    expect_now(1, 0, "R3 wait for master clock");
    mclk_ok = 1;
    cyc(1);
    expect_now(2, 0, "R4 init with pump on");
    cp_done = 1;
    cyc(3);
    expect_now(2, 0, "R4 hold without frame clocks");
    lrck_ok = 1; sclk_ok = 1;
    cyc(1);
    expect_now(3, 0, "R4 to ratio detect");
    cyc(2);
    expect_now(3, 0, "R5 wait for ratio");
    sclk_ok = 0;
    cyc(1);
    expect_now(2, 0, "R5 bit clock loss back to init");
    sclk_ok = 1;
    cyc(1);
    expect_now(3, 0, "R5 re-enter ratio detect");
    ratio_ok = 1;
    cyc(1);
    expect_now(4, 0, "R6 power-up enables");
    cyc(PUPC - 1);
    expect_now(4, 0, "R6 power-up dwell");
    cyc(1);
    expect_now(5, 0, "R7 normal operation");
    ratio_ok = 0; ratio_chg = 1;
    cyc(1);
    expect_now(6, 0, "R8 ratio change mutes");
    ratio_chg = 0;
    cyc(2);
    expect_now(6, 0, "R8 stay muted without ratio");
    ratio_ok = 1;
    cyc(1);
    expect_now(5, 0, "R8 valid ratio unmutes");
    mclk_ok = 0;
    cyc(1);
    expect_now(1, 0, "R9 master clock loss");
    mclk_ok = 1;
    cyc(3);
    expect_now(4, 0, "R9 re-sequence to power-up");
    mclk_ok = 0;
    cyc(1);
    expect_now(1, 0, "R9 clock loss from power-up");
    mclk_ok = 1;
    cyc(2);
    arst_n = 0;
    #1;
    expect_now(0, 0, "R2 asynchronous reset entry");
    cyc(3);
    arst_n = 1;
    cyc(PUPC + 5);
    expect_now(4, 0, "R10 one edge before normal");
    cyc(1);
    expect_now(5, 0, "R10 startup latency");
    expect_now(5, 0, "R1 one-hot normal code");
    cyc(LIM + 10);
    expect_now(5, 0, "R11 no timeout after good start");
    arst_n = 0; mclk_ok = 0;
    cyc(3);
    arst_n = 1;
    cyc(LIM - 10);
    expect_now(1, 0, "R11 before limit");
    cyc(20);
    expect_now(1, 1, "R11 timeout raised");
    mclk_ok = 1;
    cyc(1);
    expect_now(2, 1, "R11 timeout sticky");
    cyc(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule